// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits next to a small processor core and chooses which pending interrupt the core takes. There are five request inputs. A non-maskable trap input has the highest priority. Three restart lines follow, at levels 7.5, 6.5 and 5.5. A general request line has the lowest priority. The block holds the global interrupt enable and a mask for each restart line.

Once per instruction, the core asserts a sample strobe on its next-to-last clock. The block then resolves priority among the requests that qualify. One cycle later it reports the decision in one of two ways:

- a fixed internal restart vector, for the trap and restart lines, or
- a request for an external acknowledge cycle, for the general line. In this case the core also holds its program counter, so that an externally supplied restart or call can be inserted.

The core can read the masks, the enable state and the pending lines through a status port. It writes the masks through a control port.

Top module: `restart_irq_ctrl`

## Requirements
- R1: When several requests qualify at one sample, the highest one wins, in this order: trap, 7.5, 6.5, 5.5, general. The vectors are 0x0024 for trap, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5.
- R2: The trap is taken regardless of masks and enable. It needs `trap_i` high at the sample and a rising edge on it since the trap was last taken.
- R3: Decisions are made only at a clock edge where `sample_i` is high. The outputs `take_o`, `auto_o`, `inta_o` and `vec_o` change at that edge and hold for one cycle. Without a take, all of them are zero.
- R4: A taken trap or restart line gives `auto_o`=1, `inta_o`=0 and its vector. A taken general request gives `inta_o`=1 (acknowledge requested, PC increment held), `auto_o`=0 and `vec_o`=0.
- R5: The enable is 0 after reset. `ei_i` sets it and `di_i` clears it. Taking any maskable request clears it at the same edge, and this has precedence over `ei_i`. Taking the trap leaves it unchanged. Restart lines and the general line need the enable set.
- R6: A control write (`ctl_wr_i`) with bit 3 set loads the masks from bits 2:0: bit 0 is 5.5, bit 1 is 6.5, bit 2 is 7.5, and 1 means masked. A write with bit 3 clear leaves the masks unchanged. All masks are set after reset, and a masked line is never taken.
- R7: A rising edge on `rst75_i` latches a 7.5 request even while the line is masked or disabled. The latch holds after the input falls. It clears when 7.5 is taken or on a control write with bit 4 set.
- R8: Lines 6.5, 5.5 and the general line are level-sensitive. They count only if they are high at the sample edge.
- R9: `status_o` reads as follows: masks in [2:0], enable in [3], 5.5 level in [4], 6.5 level in [5], 7.5 latch in [6], and trap pending (armed and high) in [7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request |
| rst75_i | input | 1 | Edge-latched restart request, level 7.5 |
| rst65_i | input | 1 | Level restart request, level 6.5 |
| rst55_i | input | 1 | Level restart request, level 5.5 |
| intr_i | input | 1 | General request, vectored externally |
| sample_i | input | 1 | Strobe from the core on the next-to-last clock of an instruction |
| ei_i | input | 1 | Set enable |
| di_i | input | 1 | Clear enable |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 5 | Masks [2:0], mask load [3], 7.5 latch clear [4] |
| status_o | output | 8 | Masks, enable and pending lines |
| take_o | output | 1 | An interrupt was taken at the last sample |
| auto_o | output | 1 | Taken interrupt uses an internal restart vector |
| inta_o | output | 1 | Acknowledge cycle requested; PC increment held |
| vec_o | output | 16 | Restart vector of the taken interrupt |

## Verification
Acceptance of a maskable request and an enable instruction can fall on the same edge. The bench provokes this by driving `ei_i` together with `sample_i` and judges it by reading the enable bit of `status_o` afterwards. Service of the 7.5 latch can also coincide with a fresh edge or a mask write. The bench handles this by checking the latch bit in status after each service or clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 5;
  localparam int VEC_W  = 16;
  localparam int CTL_W  = 5;
  localparam int STAT_W = 8;
  localparam int NMASK  = 3;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55, SRC_INTR
  } src_e;

  // req[4]=trap, [3]=7.5, [2]=6.5, [1]=5.5, [0]=general
  function automatic src_e pick_src(input logic [NSRC-1:0] req);
    if (req[4])      return SRC_TRAP;
    else if (req[3]) return SRC_R75;
    else if (req[2]) return SRC_R65;
    else if (req[1]) return SRC_R55;
    else if (req[0]) return SRC_INTR;
    return SRC_NONE;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input src_e s);
    case (s)
      SRC_TRAP: return VEC_TRAP;
      SRC_R75:  return VEC_R75;
      SRC_R65:  return VEC_R65;
      SRC_R55:  return VEC_R55;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic held_o
);
  logic lvl_q;
  logic held_q;
  logic rise;

  assign rise   = lvl_i & ~lvl_q;
  assign held_o = held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (clr_i)     held_q <= 1'b0;
      else if (rise) held_q <= 1'b1;
    end
  end

  // R7: a latched request stays until it is cleared
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr_i) |=> held_q);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output src_e            sel_o
);
  assign sel_o = pick_src(req_i);

  // R1: nothing is chosen without a request
  always_comb begin
    a_r1_none: assert ((req_i != '0) || (sel_o == SRC_NONE));
  end
endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              rst75_i,
  input  logic              rst65_i,
  input  logic              rst55_i,
  input  logic              intr_i,
  input  logic              sample_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              take_o,
  output logic              auto_o,
  output logic              inta_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int B_LOAD = NMASK;
  localparam int B_CLR  = NMASK + 1;

  logic             en_q;
  logic [NMASK-1:0] mask_q;
  logic             trap_armed, pend75;
  logic             clr_trap, clr75;
  logic [NSRC-1:0]  req;
  src_e             sel;
  logic             accept, accept_mask;
  logic             take_q, auto_q, inta_q;
  logic [VEC_W-1:0] vec_q;

  irq_edge_latch u_trap_lat (
    .clk(clk), .rst_n(rst_n), .lvl_i(trap_i), .clr_i(clr_trap), .held_o(trap_armed));
  irq_edge_latch u_r75_lat (
    .clk(clk), .rst_n(rst_n), .lvl_i(rst75_i), .clr_i(clr75), .held_o(pend75));

  assign req = {trap_i & trap_armed,
                pend75  & en_q & ~mask_q[2],
                rst65_i & en_q & ~mask_q[1],
                rst55_i & en_q & ~mask_q[0],
                intr_i  & en_q};

  irq_prio_sel u_sel (.req_i(req), .sel_o(sel));

  assign accept      = sample_i && (sel != SRC_NONE);
  assign accept_mask = accept && (sel != SRC_TRAP);
  assign clr_trap    = accept && (sel == SRC_TRAP);
  assign clr75       = (accept && (sel == SRC_R75)) || (ctl_wr_i && ctl_wdata_i[B_CLR]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
      take_q <= 1'b0;
      auto_q <= 1'b0;
      inta_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (accept_mask) en_q <= 1'b0;
      else if (di_i)   en_q <= 1'b0;
      else if (ei_i)   en_q <= 1'b1;
      if (ctl_wr_i && ctl_wdata_i[B_LOAD]) mask_q <= ctl_wdata_i[NMASK-1:0];
      take_q <= accept;
      auto_q <= accept && (sel != SRC_INTR);
      inta_q <= accept && (sel == SRC_INTR);
      vec_q  <= accept ? src_vector(sel) : '0;
    end
  end

  assign take_o   = take_q;
  assign auto_o   = auto_q;
  assign inta_o   = inta_q;
  assign vec_o    = vec_q;
  assign status_o = {trap_i & trap_armed, pend75, rst65_i, rst55_i, en_q, mask_q};

  // R4: never both an internal vector and an acknowledge request
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({auto_o, inta_o}));
  // R4 / R5: acknowledge only if the enable was set at the sample
  a_r4_inta_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> $past(en_q));
  // R3: a take follows a sample strobe
  a_r3_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));
  // R3: outputs quiet without a take
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (!auto_o && !inta_o && vec_o == '0));
  // R5: a maskable take leaves the enable clear
  a_r5_en_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o != VEC_TRAP) |-> !en_q);
  // R2: an armed, high trap at a sample always wins
  a_r2_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && trap_i && trap_armed) |=> (vec_o == VEC_TRAP));
endmodule

// File: tb/restart_irq_ctrl_tb.sv
module restart_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {levels trap,75,65,55,intr [27:23], mask [22:20], en [19], take [18], auto [17], inta [16], vec [15:0]}
  localparam logic [27:0] TBL [NV] = '{
    {5'b11111, 3'b000, 1'b1, 3'b110, 16'h0024},
    {5'b01111, 3'b000, 1'b1, 3'b110, 16'h003C},
    {5'b00111, 3'b000, 1'b1, 3'b110, 16'h0034},
    {5'b00011, 3'b000, 1'b1, 3'b110, 16'h002C},
    {5'b00001, 3'b000, 1'b1, 3'b101, 16'h0000},
    {5'b00001, 3'b000, 1'b0, 3'b000, 16'h0000},
    {5'b01100, 3'b100, 1'b1, 3'b110, 16'h0034},
    {5'b01111, 3'b111, 1'b1, 3'b101, 16'h0000},
    {5'b10000, 3'b111, 1'b0, 3'b110, 16'h0024},
    {5'b00010, 3'b000, 1'b0, 3'b000, 16'h0000},
    {5'b00000, 3'b000, 1'b1, 3'b000, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
  logic sample_i = 0, ei_i = 0, di_i = 0, ctl_wr_i = 0;
  logic [4:0]  ctl_wdata_i = 0;
  logic [7:0]  status_o;
  logic        take_o, auto_o, inta_o;
  logic [15:0] vec_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i), .rst65_i(rst65_i),
    .rst55_i(rst55_i), .intr_i(intr_i), .sample_i(sample_i), .ei_i(ei_i), .di_i(di_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .status_o(status_o),
    .take_o(take_o), .auto_o(auto_o), .inta_o(inta_o), .vec_o(vec_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_lv(input logic [4:0] lv);
    {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = lv;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; set_lv(5'b0); sample_i = 0; ei_i = 0; di_i = 0; ctl_wr_i = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic ctl(input logic [4:0] w);
    @(negedge clk); ctl_wr_i = 1; ctl_wdata_i = w;
    @(negedge clk); ctl_wr_i = 0; ctl_wdata_i = 0;
  endtask

  task automatic enable();
    @(negedge clk); ei_i = 1;
    @(negedge clk); ei_i = 0;
  endtask

  // pulse sample for one edge; outputs are checked at the next negedge
  task automatic sample();
    @(negedge clk); sample_i = 1;
    @(negedge clk); sample_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R9 reset status", status_o, 8'h07);
    chk("R3 reset take", take_o, 0);

    // table: R1 R2 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      do_reset();
      ctl({2'b01, TBL[i][22:20]});
      if (TBL[i][19]) enable();
      @(negedge clk); set_lv(TBL[i][27:23]);
      sample();
      chk($sformatf("R1/R4 vec%0d take", i), take_o, TBL[i][18]);
      chk($sformatf("R4 vec%0d auto", i), auto_o, TBL[i][17]);
      chk($sformatf("R4 vec%0d inta", i), inta_o, TBL[i][16]);
      chk($sformatf("R1 vec%0d vector", i), vec_o, TBL[i][15:0]);
    end

    // R5: trap take keeps enable; maskable take clears it even with ei
    do_reset(); ctl(5'b01000); enable();
    @(negedge clk); trap_i = 1;
    sample();
    chk("R5 enable after trap", status_o[3], 1);
    @(negedge clk); trap_i = 0; rst55_i = 1; ei_i = 1; sample_i = 1;
    @(negedge clk); ei_i = 0; sample_i = 0;
    chk("R5 take 5.5 with ei", vec_o, 16'h002C);
    chk("R5 enable cleared", status_o[3], 0);
    @(negedge clk); rst55_i = 0; di_i = 0;

    // R2: trap not retaken without new edge
    do_reset();
    @(negedge clk); trap_i = 1;
    sample();
    chk("R2 first trap", vec_o, 16'h0024);
    sample();
    chk("R2 no rearm", take_o, 0);
    @(negedge clk); trap_i = 0;
    @(negedge clk); trap_i = 1;
    sample();
    chk("R2 rearmed", vec_o, 16'h0024);

    // R3: no sample, no take
    do_reset(); ctl(5'b01000); enable();
    @(negedge clk); rst65_i = 1;
    @(negedge clk); @(negedge clk);
    chk("R3 no sample", take_o, 0);

    // R8: 6.5 pulse gone before sample
    @(negedge clk); rst65_i = 0;
    sample();
    chk("R8 level gone", take_o, 0);

    // R6: write without load bit leaves masks
    ctl(5'b00101);
    chk("R6 no load", status_o[2:0], 3'b000);
    ctl(5'b01101);
    chk("R6 load", status_o[2:0], 3'b101);

    // R7: edge latched while masked, served after unmask
    do_reset(); ctl(5'b01100); enable();
    @(negedge clk); rst75_i = 1;
    @(negedge clk); rst75_i = 0;
    @(negedge clk);
    chk("R7 latched while masked", status_o[6], 1);
    sample();
    chk("R7 masked not taken", take_o, 0);
    ctl(5'b01000);
    sample();
    chk("R7 taken after unmask", vec_o, 16'h003C);
    chk("R7 cleared on service", status_o[6], 0);
    @(negedge clk); rst75_i = 1;
    @(negedge clk); rst75_i = 0;
    @(negedge clk);
    chk("R7 relatched", status_o[6], 1);
    ctl(5'b10000);
    chk("R7 cleared by write", status_o[6], 0);

    // R9: status levels
    @(negedge clk); rst55_i = 1; rst65_i = 1; trap_i = 1;
    @(negedge clk);
    chk("R9 status levels", status_o[7:4], 4'b1011);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule